// File: doc/BRIEF.md
# Key Input Interrupt Controller

This block turns edges on nine external key inputs into prioritized interrupt requests for a CPU. The inputs form two ports: a byte-wide port A (pins 0–7) and a single-pin port B (pin 8). They feed three interrupt groups. Group 0 is pins 0–3, group 1 is pins 4–7 and group 2 is pin 8.

Every pin is resynchronized and has its own edge polarity. Any qualifying edge on a pin latches the pending flag of its group. Software clears a flag by writing a one to it. Each port has one two-bit priority level, and each group has an enable bit. The block compares every enabled, pending group against the CPU's current mask level. It outputs a request, the winning level and the winning source.

Software reaches all settings through a simple byte register port. Reads are combinational.

Top module: `kint_ctrl`

## Requirements
- R1: After reset, the polarity registers read 0xFF at address 0x52 and 0x01 at address 0x53. The priority, enable and pending registers read 0. `irq_o` is 0.
- R2: A polarity bit of 1 makes its pin trigger on a falling edge, and a 0 makes it trigger on a rising edge. An edge of the other direction leaves the pending flags unchanged. Pin bits 0–7 are at address 0x52, bits 7:0. Pin 8 is at address 0x53, bit 0.
- R3: The pending flags sit at address 0x25. A qualifying edge on pins 0–3 sets bit 3 (group 0). An edge on pins 4–7 sets bit 4 (group 1). An edge on pin 8 sets bit 5 (group 2).
- R4: A pending flag is set by a qualifying edge regardless of the enable and priority settings.
- R5: Writing 1 to a pending bit at 0x25 clears it, and writing 0 leaves it unchanged.
- R6: If a qualifying edge and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R7: A group requests only when three conditions hold: its flag is set, its enable bit is 1, and its port priority is strictly greater than `cpu_lvl_i`. The enable bits sit at 0x23, bits 3/4/5 for groups 0/1/2. The port A priority is at 0x20, bits 7:6, and is shared by groups 0 and 1. The port B priority is at 0x21, bits 1:0. Codes 3..0 mean level 3..0.
- R8: When several groups request, `irq_lvl_o` gives the highest requesting level. `irq_src_o` names the first group at that level in the order 0, 1, 2 (codes 0, 1, 2). When nothing requests, `irq_o` is 0.
- R9: Unmapped bits read 0, and `rdata_o` is 0 while `re_i` is low.
- R10: A pin change driven before clock edge k is visible in the pending flag after edge k+2 and not after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 9 | Key inputs; bits 7:0 are port A, bit 8 is port B |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, combinational |
| cpu_lvl_i | input | 2 | Current CPU interrupt mask level |
| irq_o | output | 1 | Interrupt request valid |
| irq_lvl_o | output | 2 | Level of the winning request |
| irq_src_o | output | 2 | Winning group: 0, 1 or 2 |

## Verification
The embedded properties check some rules on every cycle. A request is always above the mask and backed by a set, enabled flag. No requesting group exceeds the reported level. A flag only falls after a clearing write. An edge event always leaves its flag set, even when a clear coincides with it. The bench scenarios are what show that each pin maps to the right group, that edge direction is respected per pin, and that the read-back layout is correct. They also show the exact two-edge resynchronization delay and the tie order between equal levels.

// File: rtl/kint_pkg.sv
package kint_pkg;
  localparam int NGRP = 3;
  typedef logic [1:0] lvl_t;
  typedef enum logic [1:0] {
    SRC_G0 = 2'd0,
    SRC_G1 = 2'd1,
    SRC_G2 = 2'd2
  } src_e;
endpackage

// File: rtl/kint_edge.sv
module kint_edge #(
  parameter int N_PIN  = 9,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_PIN-1:0] pin_i,
  input  logic [N_PIN-1:0] fall_sel_i,
  output logic [N_PIN-1:0] ev_o
);
  for (genvar p = 0; p < N_PIN; p++) begin : g_pin
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sync_q <= '1;
        prev_q <= 1'b1;
      end else begin
        sync_q <= {sync_q[STAGES-2:0], pin_i[p]};
        prev_q <= sync_q[STAGES-1];
      end
    end
    // fall: 1->0, rise: 0->1 between consecutive synchronized samples
    assign ev_o[p] = fall_sel_i[p] ? (prev_q & ~sync_q[STAGES-1])
                                   : (~prev_q & sync_q[STAGES-1]);
  end
endmodule

// File: rtl/kint_regs.sv
module kint_regs
  import kint_pkg::*;
#(
  parameter int          N_PIN_A = 8,
  parameter int          N_LO    = 4,
  parameter logic [7:0]  A_PRIO_A = 8'h20,
  parameter logic [7:0]  A_PRIO_B = 8'h21,
  parameter logic [7:0]  A_EN     = 8'h23,
  parameter logic [7:0]  A_PEND   = 8'h25,
  parameter logic [7:0]  A_POL_A  = 8'h52,
  parameter logic [7:0]  A_POL_B  = 8'h53,
  localparam int         N_PIN    = N_PIN_A + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       addr_i,
  input  logic [7:0]       wdata_i,
  input  logic             we_i,
  input  logic             re_i,
  output logic [7:0]       rdata_o,
  input  logic [N_PIN-1:0] ev_i,
  output logic [N_PIN-1:0] fall_sel_o,
  output lvl_t             prio_a_o,
  output lvl_t             prio_b_o,
  output logic [NGRP-1:0]  en_o,
  output logic [NGRP-1:0]  pend_o
);
  logic [N_PIN-1:0] pol_q;
  lvl_t             prio_a_q, prio_b_q;
  logic [NGRP-1:0]  en_q, pend_q, grp_set, grp_clr;

  assign grp_set[0] = |ev_i[N_LO-1:0];
  assign grp_set[1] = |ev_i[N_PIN_A-1:N_LO];
  assign grp_set[2] = ev_i[N_PIN_A];
  assign grp_clr    = (we_i && addr_i == A_PEND) ? wdata_i[5:3] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q    <= '1;
      prio_a_q <= '0;
      prio_b_q <= '0;
      en_q     <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        A_POL_A:  pol_q[N_PIN_A-1:0] <= wdata_i[N_PIN_A-1:0];
        A_POL_B:  pol_q[N_PIN_A]     <= wdata_i[0];
        A_PRIO_A: prio_a_q           <= wdata_i[7:6];
        A_PRIO_B: prio_b_q           <= wdata_i[1:0];
        A_EN:     en_q               <= wdata_i[5:3];
        default: ;
      endcase
    end
  end

  // set dominates a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= grp_set | (pend_q & ~grp_clr);
  end

  always_comb begin
    rdata_o = '0;
    if (re_i) begin
      unique case (addr_i)
        A_POL_A:  rdata_o = pol_q[N_PIN_A-1:0];
        A_POL_B:  rdata_o = {7'b0, pol_q[N_PIN_A]};
        A_PRIO_A: rdata_o = {prio_a_q, 6'b0};
        A_PRIO_B: rdata_o = {6'b0, prio_b_q};
        A_EN:     rdata_o = {2'b0, en_q, 3'b0};
        A_PEND:   rdata_o = {2'b0, pend_q, 3'b0};
        default:  rdata_o = '0;
      endcase
    end
  end

  assign fall_sel_o = pol_q;
  assign prio_a_o   = prio_a_q;
  assign prio_b_o   = prio_b_q;
  assign en_o       = en_q;
  assign pend_o     = pend_q;

  for (genvar g = 0; g < NGRP; g++) begin : g_chk
    AST_FLAG_FALL_ON_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pend_q[g]) |-> $past(we_i && addr_i == A_PEND && wdata_i[3+g])); // R5
    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grp_set[g] |=> pend_q[g]); // R6
  end
endmodule

// File: rtl/kint_arb.sv
module kint_arb
  import kint_pkg::*;
(
  input  logic [NGRP-1:0] pend_i,
  input  logic [NGRP-1:0] en_i,
  input  lvl_t            prio_a_i,
  input  lvl_t            prio_b_i,
  input  lvl_t            cpu_lvl_i,
  output logic            irq_o,
  output lvl_t            irq_lvl_o,
  output src_e            irq_src_o
);
  lvl_t grp_lvl [NGRP];
  logic [NGRP-1:0] req;

  assign grp_lvl[0] = prio_a_i;
  assign grp_lvl[1] = prio_a_i;
  assign grp_lvl[2] = prio_b_i;

  for (genvar g = 0; g < NGRP; g++) begin : g_req
    assign req[g] = pend_i[g] & en_i[g] & (grp_lvl[g] > cpu_lvl_i);
  end

  // strict compare keeps the lower index on equal levels
  always_comb begin
    irq_o     = 1'b0;
    irq_lvl_o = '0;
    irq_src_o = SRC_G0;
    for (int g = 0; g < NGRP; g++) begin
      if (req[g] && (!irq_o || grp_lvl[g] > irq_lvl_o)) begin
        irq_o     = 1'b1;
        irq_lvl_o = grp_lvl[g];
        irq_src_o = src_e'(g[1:0]);
      end
    end
  end
endmodule

// File: rtl/kint_ctrl.sv
module kint_ctrl
  import kint_pkg::*;
#(
  parameter int N_PIN_A = 8,
  parameter int N_LO    = 4,
  parameter int STAGES  = 2,
  localparam int N_PIN  = N_PIN_A + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_PIN-1:0] pin_i,
  input  logic [7:0]       addr_i,
  input  logic [7:0]       wdata_i,
  input  logic             we_i,
  input  logic             re_i,
  output logic [7:0]       rdata_o,
  input  logic [1:0]       cpu_lvl_i,
  output logic             irq_o,
  output logic [1:0]       irq_lvl_o,
  output logic [1:0]       irq_src_o
);
  logic [N_PIN-1:0] ev, fall_sel;
  lvl_t             prio_a, prio_b;
  logic [NGRP-1:0]  en, pend;
  src_e             src;

  kint_edge #(.N_PIN(N_PIN), .STAGES(STAGES)) u_edge (
    .clk_i, .rst_ni, .pin_i, .fall_sel_i(fall_sel), .ev_o(ev)
  );

  kint_regs #(.N_PIN_A(N_PIN_A), .N_LO(N_LO)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i, .re_i, .rdata_o,
    .ev_i(ev), .fall_sel_o(fall_sel), .prio_a_o(prio_a), .prio_b_o(prio_b),
    .en_o(en), .pend_o(pend)
  );

  kint_arb u_arb (
    .pend_i(pend), .en_i(en), .prio_a_i(prio_a), .prio_b_i(prio_b),
    .cpu_lvl_i, .irq_o, .irq_lvl_o, .irq_src_o(src)
  );

  assign irq_src_o = src;

  AST_REQ_ABOVE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_lvl_o > cpu_lvl_i); // R7
  AST_REQ_BACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend[irq_src_o] && en[irq_src_o])); // R7
  AST_SRC_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_src_o != 2'd3); // R8
  AST_LVL_MAX_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend[0] | pend[1]) && (en[0] | en[1]) && prio_a > cpu_lvl_i && (pend & en & 3'b011) != 0)
      |-> (irq_o && irq_lvl_o >= prio_a)); // R8
  AST_LVL_MAX_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend[2] && en[2] && prio_b > cpu_lvl_i) |-> (irq_o && irq_lvl_o >= prio_b)); // R8
endmodule

// File: tb/kint_ctrl_tb.sv
module kint_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] pins = '1;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic       we = 1'b0, re = 1'b0;
  logic [1:0] cpu_lvl = '0, irq_lvl, irq_src;
  logic       irq;
  int         n_chk = 0, n_fail = 0;

  // model state
  logic [8:0] m_pol = '1;
  logic [1:0] m_pa = '0, m_pb = '0;
  logic [2:0] m_en = '0, m_pend = '0;

  always #10 clk = ~clk;

  kint_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pins), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .cpu_lvl_i(cpu_lvl),
    .irq_o(irq), .irq_lvl_o(irq_lvl), .irq_src_o(irq_src)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; re = 1'b1; #1 d = rdata; re = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [2:0] grp_of(input logic [8:0] ev);
    return {ev[8], |ev[7:4], |ev[3:0]};
  endfunction

  function automatic logic [2:0] qual(input logic [8:0] o, input logic [8:0] n);
    return grp_of((m_pol & o & ~n) | (~m_pol & ~o & n));
  endfunction

  // expected {irq, lvl, src}
  function automatic logic [4:0] exp_arb();
    logic [1:0] lv [3];
    logic v = 1'b0; logic [1:0] bl = '0, bs = '0;
    lv[0] = m_pa; lv[1] = m_pa; lv[2] = m_pb;
    for (int g = 0; g < 3; g++)
      if (m_pend[g] && m_en[g] && lv[g] > cpu_lvl && (!v || lv[g] > bl)) begin
        v = 1'b1; bl = lv[g]; bs = 2'(g);
      end
    return {v, bl, bs};
  endfunction

  task automatic check_state(input string tag);
    logic [7:0] d; logic [4:0] e;
    rd(8'h25, d);
    chk(d == {2'b0, m_pend, 3'b0}, {tag, " pend R3"}, d, {2'b0, m_pend, 3'b0});
    e = exp_arb();
    #1;
    chk(irq == e[4], {tag, " irq R7"}, irq, e[4]);
    if (e[4]) chk({irq_lvl, irq_src} == e[3:0], {tag, " lvl/src R8"}, {irq_lvl, irq_src}, e[3:0]);
  endtask

  task automatic set_pins(input logic [8:0] n);
    m_pend |= qual(pins, n);
    @(negedge clk); pins = n;
    idle(4);
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    void'($urandom(32'd1234));
    idle(3); rst_n = 1'b1; idle(2);

    // R1 reset values
    rd(8'h52, d); chk(d == 8'hFF, "R1 pol A", d, 8'hFF);
    rd(8'h53, d); chk(d == 8'h01, "R1 pol B", d, 8'h01);
    rd(8'h20, d); chk(d == 8'h00, "R1 prio A", d, 0);
    rd(8'h21, d); chk(d == 8'h00, "R1 prio B", d, 0);
    rd(8'h23, d); chk(d == 8'h00, "R1 enable", d, 0);
    rd(8'h25, d); chk(d == 8'h00, "R1 pend", d, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);

    // R9 unmapped / no read strobe
    wr(8'h20, 8'hFF); m_pa = 2'd3;
    rd(8'h20, d); chk(d == 8'hC0, "R9 prio A masked bits", d, 8'hC0);
    rd(8'h30, d); chk(d == 8'h00, "R9 unmapped addr", d, 0);
    @(negedge clk); addr = 8'h52; #1 chk(rdata == 8'h00, "R9 re low", rdata, 0);
    wr(8'h20, 8'h00); m_pa = 2'd0;

    // R10 latency: falling on pin 2 (default falling)
    @(negedge clk); pins[2] = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    addr = 8'h25; re = 1'b1; #1 chk(rdata[3] == 1'b0, "R10 not after k+1", rdata[3], 0); re = 1'b0;
    @(posedge clk); @(negedge clk);
    addr = 8'h25; re = 1'b1; #1 chk(rdata[3] == 1'b1, "R10 set after k+2", rdata[3], 1); re = 1'b0;
    m_pend[0] = 1'b1;

    // R4 flag set although disabled, prio 0
    check_state("R4 disabled");
    // R5 write 0 no effect, write 1 clears
    wr(8'h25, 8'h00); check_state("R5 write0");
    wr(8'h25, 8'h08); m_pend[0] = 1'b0; check_state("R5 write1");
    pins[2] = 1'b1; idle(4); // rising, ignored under falling polarity
    check_state("R2 opposite edge");

    // R6 set vs clear same cycle on pin 8
    @(negedge clk); pins[8] = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    addr = 8'h25; wdata = 8'h20; we = 1'b1;
    @(negedge clk); we = 1'b0;
    m_pend[2] = 1'b1;
    rd(8'h25, d); chk(d[5] == 1'b1, "R6 set wins", d[5], 1);
    wr(8'h25, 8'h38); m_pend = '0;
    set_pins(9'h1FF); check_state("R2 rise ignored pin8");

    // R2 rising polarity on pin 5
    wr(8'h52, 8'hDF); m_pol[5] = 1'b0;
    set_pins(9'h1DF); check_state("R2 fall ignored rise-sel");
    set_pins(9'h1FF); check_state("R2 rise on rise-sel");
    chk(m_pend == 3'b010, "R3 pin5 to group1", m_pend, 3'b010);

    // R8 tie order: groups 0,1 share prio A
    wr(8'h23, 8'h38); m_en = 3'b111;
    wr(8'h20, 8'h80); m_pa = 2'd2;
    wr(8'h21, 8'h02); m_pb = 2'd2;
    set_pins(9'h0FE);  // fall pin0 and pin8
    check_state("R8 tie");
    chk(irq_src == 2'd0 && irq_lvl == 2'd2, "R8 tie src0", {irq_lvl, irq_src}, 4'h8);
    wr(8'h25, 8'h08); m_pend[0] = 1'b0; check_state("R8 next src1");
    chk(irq_src == 2'd1, "R8 src1", irq_src, 1);
    wr(8'h21, 8'h03); m_pb = 2'd3; check_state("R8 higher B");
    chk(irq_src == 2'd2 && irq_lvl == 2'd3, "R8 src2 lvl3", {irq_lvl, irq_src}, 4'hE);
    cpu_lvl = 2'd3; check_state("R7 masked");
    chk(irq == 1'b0, "R7 mask equal", irq, 0);
    cpu_lvl = 2'd0;
    wr(8'h25, 8'h38); m_pend = '0;
    set_pins(9'h1FF);

    // random phase
    for (int it = 0; it < 400; it++) begin
      logic [7:0] r;
      r = 8'($urandom);
      case ($urandom % 6)
        0: begin wr(8'h52, r); m_pol[7:0] = r; end
        1: begin wr(8'h53, r); m_pol[8] = r[0]; end
        2: begin wr(8'h20, r); m_pa = r[7:6]; wr(8'h21, ~r); m_pb = ~r[1:0]; end
        3: begin wr(8'h23, r); m_en = r[5:3]; end
        4: begin wr(8'h25, r); m_pend &= ~r[5:3]; end
        default: begin
          cpu_lvl = 2'($urandom);
          set_pins(pins ^ 9'($urandom));
        end
      endcase
      check_state("RND R2");
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule